// File: doc/BRIEF.md
# Free-Running Timer with Capture and Compare

The block is a 16-bit up-counter that runs without stopping. It is paced by a power-of-two divider on the system clock. Two compare registers watch the counter. A match on either register toggles a single output pin, so the pair sets both edges of one waveform. A match on the first compare register can also send the counter back to zero, which turns the free-running count into a programmable period.

Two capture channels sample external inputs through a two-flop synchronizer. On the edge chosen for each channel, the channel stores the current counter value. Overflow, the two compare matches and the two captures each set a sticky flag. Software clears a flag by writing a one to it.

Software reaches every register through a plain single-cycle write strobe and a combinational read port. No part of the block streams data, so it has no valid/ready handshake and never applies back-pressure. A write always lands on the clock edge where the strobe is high.

Top module: `frt_capcmp`

## Requirements
- R1: After reset, the counter, the control register, the compare registers, the capture registers, all flags and `cmp_out` read as zero, and the divider ratio is 1.
- R2: With CTRL[2:0] = n, the counter advances once every 2^n clocks. Writing V to COUNT loads V and restarts the divider phase, so k clock edges after that write the counter reads V + floor(k / 2^n), as long as no wrap or clear occurs.
- R3: When the counter steps from 0xFFFF to 0x0000, FLAGS bit 0 is set.
- R4: When CTRL[3] is 1, a count step taken while the counter equals CMP0 loads 0 in place of the increment. When CTRL[3] is 0, the counter passes the CMP0 value and keeps counting.
- R5: A count step taken while the counter equals CMP0 sets FLAGS bit 1. A count step taken while it equals CMP1 sets FLAGS bit 2. On the clock edge of a COUNT write, no match is evaluated.
- R6: `cmp_out` inverts once on every clock edge that carries a CMP0 match, a CMP1 match, or both, and holds its value otherwise.
- R7: Capture channel i uses CTRL[5+2i:4+2i] as its edge select: 00 = off, 01 = rising, 10 = falling, 11 = both. An edge that is not selected leaves the capture register and the flag unchanged.
- R8: A selected edge on `cap_in[i]` copies the counter value into CAP register i and sets FLAGS bit 3+i. The event takes effect on the third rising clock edge after the input changes, which covers the two synchronizer stages and the edge detector.
- R9: Flags are sticky. A write to FLAGS clears exactly the bits written as 1. If a flag is set and cleared in the same cycle, the flag stays set.
- R10: The register addresses are CTRL=0, COUNT=1, CMP0=2, CMP1=3, FLAGS=4, CAP0=5, CAP1=6. `irq_flags` always mirrors FLAGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| cap_in | input | 2 | Capture inputs, one per channel, asynchronous |
| cmp_out | output | 1 | Waveform driven by the compare pair |
| irq_flags | output | 5 | Sticky flags: overflow, CMP0, CMP1, CAP0, CAP1 |

## Verification
Two functions can fall in the same cycle: a hardware event setting a flag, and a software write-one clearing that same flag. The bench changes a capture input and then times a FLAGS write so that its clock edge coincides with the edge on which the synchronized event lands, which is the third edge after the input change. The check passes if the flag still reads 1 afterwards and the capture register holds the counter value. A second, plain clear then returns the flag to 0.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_COUNT = 1;
  localparam int unsigned A_CMP0  = 2;
  localparam int unsigned A_CMP1  = 3;
  localparam int unsigned A_FLAGS = 4;
  localparam int unsigned A_CAP0  = 5;
  // flag bit positions
  localparam int unsigned F_OVF  = 0;
  localparam int unsigned F_CMP0 = 1;
  localparam int unsigned F_CMP1 = 2;
  localparam int unsigned F_CAP0 = 3;
  // capture edge select codes
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] phase;
  logic [PW-1:0] mask;

  assign mask = ~({PW{1'b1}} << div);
  assign tick = (phase & mask) == mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else              phase <= phase + PW'(1);
  end

  // R2: with a ratio above 1, two ticks never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !restart) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && !load && !clr && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (tick && clr) cnt <= '0;
    else if (tick)       cnt <= cnt + CNT_W'(1);
  end

  // R2: the counter moves only on a tick or a load
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/frt_capture.sv
module frt_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output logic [CNT_W-1:0] value
);
  logic [2:0] sync_q;
  logic       rise, fall;

  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];
  assign hit  = (edge_sel[0] & rise) | (edge_sel[1] & fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      value  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin};
      if (hit) value <= count;
    end
  end

  // R8: a capture event stores the counter value seen at that edge
  p_cap_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (value == $past(count)));
endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
  import frt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 3,
  parameter int NCAP   = 2,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  input  logic [NCAP-1:0]      cap_in,
  output logic                 cmp_out,
  output logic [3+NCAP-1:0]    irq_flags
);
  localparam int NFLAG  = F_CAP0 + NCAP;
  localparam int CTRL_W = DIV_W + 1 + 2 * NCAP;
  localparam int CLR_B  = DIV_W;
  localparam int EDGE_B = DIV_W + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp0_q, cmp1_q, cnt;
  logic [NFLAG-1:0]  flags_q, set_v, clr_mask;
  logic              out_q, tick, wrap, cnt_we, step, hit0, hit1, clr_cnt;
  logic [NCAP-1:0]   cap_hit;
  logic [CNT_W-1:0]  cap_val [NCAP];

  assign cnt_we  = reg_wr && reg_addr == ADDR_W'(A_COUNT);
  assign step    = tick && !cnt_we;
  assign hit0    = step && cnt == cmp0_q;
  assign hit1    = step && cnt == cmp1_q;
  assign clr_cnt = ctrl_q[CLR_B] && hit0;

  frt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cnt_we),
    .div(ctrl_q[DIV_W-1:0]), .tick(tick));

  frt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_we),
    .load_val(reg_wdata), .clr(clr_cnt), .cnt(cnt), .wrap(wrap));

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    frt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[i]),
      .edge_sel(ctrl_q[EDGE_B + 2*i +: 2]), .count(cnt),
      .hit(cap_hit[i]), .value(cap_val[i]));

    // R8: the capture event raises its flag
    p_cap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[i] |=> flags_q[F_CAP0 + i]);
  end

  always_comb begin
    set_v = '0;
    set_v[F_OVF]  = wrap;
    set_v[F_CMP0] = hit0;
    set_v[F_CMP1] = hit1;
    set_v[F_CAP0 +: NCAP] = cap_hit;
    clr_mask = '0;
    if (reg_wr && reg_addr == ADDR_W'(A_FLAGS)) clr_mask = reg_wdata[NFLAG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp0_q  <= '0;
      cmp1_q  <= '0;
      flags_q <= '0;
      out_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(A_CTRL)) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (reg_wr && reg_addr == ADDR_W'(A_CMP0)) cmp0_q <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_W'(A_CMP1)) cmp1_q <= reg_wdata;
      flags_q <= (flags_q & ~clr_mask) | set_v;
      if (hit0 || hit1) out_q <= ~out_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL))  reg_rdata[CTRL_W-1:0] = ctrl_q;
    if (reg_addr == ADDR_W'(A_COUNT)) reg_rdata = cnt;
    if (reg_addr == ADDR_W'(A_CMP0))  reg_rdata = cmp0_q;
    if (reg_addr == ADDR_W'(A_CMP1))  reg_rdata = cmp1_q;
    if (reg_addr == ADDR_W'(A_FLAGS)) reg_rdata[NFLAG-1:0] = flags_q;
    for (int i = 0; i < NCAP; i++)
      if (reg_addr == ADDR_W'(A_CAP0 + i)) reg_rdata = cap_val[i];
  end

  assign cmp_out   = out_q;
  assign irq_flags = flags_q;

  // R3: the overflow flag rises only after the counter held all ones
  p_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[F_OVF]) |-> ($past(cnt) == {CNT_W{1'b1}}));
  // R4: a clearing match leaves the counter at zero
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (cnt == '0));
  // R5: a compare-1 match raises its flag
  p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> flags_q[F_CMP1]);
  // R6: any match inverts the output, otherwise it holds
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 || hit1) |=> (cmp_out != $past(cmp_out)));
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit0 || hit1) |=> $stable(cmp_out));
  // R9: a flag not named in a clear write stays set
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask)));
endmodule

// File: tb/frt_capcmp_tb.sv
module frt_capcmp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  cap_in = '0;
  logic        cmp_out;
  logic [4:0]  irq_flags;

  int checks = 0;
  int failures = 0;

  frt_capcmp u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .cmp_out(cmp_out), .irq_flags(irq_flags));

  always #5 clk = ~clk;

  // {n[2:0], start[15:0], edges[11:0], expected[15:0]}
  localparam logic [46:0] VEC [5] = '{
    {3'd0, 16'h0010, 12'd5,   16'h0015},
    {3'd1, 16'h0100, 12'd7,   16'h0103},
    {3'd3, 16'h1234, 12'd20,  16'h1236},
    {3'd7, 16'hFFF0, 12'd300, 16'hFFF2},
    {3'd2, 16'h00FF, 12'd9,   16'h0101}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic        o0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(3'd1, v); chk("R1 count", v, 16'h0);
    rd(3'd4, v); chk("R1 flags", v, 16'h0);
    rd(3'd5, v); chk("R1 cap0", v, 16'h0);
    chk("R1 cmp_out", {15'd0, cmp_out}, 16'h0);

    // R3 overflow
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'hFFFE);
    wr(3'd4, 16'h001F);
    edges(1);
    rd(3'd4, v); chk("R3 overflow flag", v, 16'h0001);
    rd(3'd1, v); chk("R3 wrapped count", v, 16'h0000);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk("R9 ovf cleared", v & 16'h1, 16'h0);

    // R2 divider table
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, {13'd0, VEC[i][46:44]});
      wr(3'd1, VEC[i][43:28]);
      edges(int'(VEC[i][27:16]));
      rd(3'd1, v); chk("R2 divided count", v, VEC[i][15:0]);
    end

    // R4 R5 R6 clear on compare 0, toggle on both
    wr(3'd2, 16'd9);
    wr(3'd3, 16'd4);
    wr(3'd0, 16'h0008);
    wr(3'd1, 16'h0000);
    o0 = cmp_out;
    wr(3'd4, 16'h001F);
    edges(5);
    rd(3'd1, v); chk("R4 count before clear", v, 16'd6);
    rd(3'd4, v); chk("R5 cmp1 flag", v, 16'h0004);
    chk("R6 toggle on cmp1", {15'd0, cmp_out}, {15'd0, ~o0});
    edges(5);
    rd(3'd1, v); chk("R4 count after clear", v, 16'd1);
    rd(3'd4, v); chk("R5 both cmp flags", v, 16'h0006);
    chk("R6 toggle on cmp0", {15'd0, cmp_out}, {15'd0, o0});

    // R4 clear disabled
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h001F);
    edges(5);
    rd(3'd1, v); chk("R4 no clear when disabled", v, 16'd6);
    rd(3'd4, v); chk("R5 flags without clear", v, 16'h0006);

    // R7 R8 capture, ch0 rising, ch1 falling, n=7
    wr(3'd0, 16'h0097);
    wr(3'd1, 16'h0500);
    wr(3'd4, 16'h001F);
    cap_in = 2'b11;
    edges(4);
    rd(3'd5, v); chk("R8 cap0 rising", v, 16'h0500);
    rd(3'd4, v); chk("R7 ch1 ignores rise", v, 16'h0008);
    rd(3'd6, v); chk("R7 cap1 untouched", v, 16'h0000);
    wr(3'd1, 16'h0600);
    cap_in = 2'b00;
    edges(4);
    rd(3'd6, v); chk("R8 cap1 falling", v, 16'h0600);
    rd(3'd5, v); chk("R7 ch0 ignores fall", v, 16'h0500);
    rd(3'd4, v); chk("R9 flags sticky", v, 16'h0018);
    wr(3'd4, 16'h0008);
    rd(3'd4, v); chk("R9 partial clear", v, 16'h0010);

    // R7 both edges on ch0, ch1 off
    wr(3'd0, 16'h0037);
    wr(3'd1, 16'h0700);
    wr(3'd4, 16'h001F);
    cap_in = 2'b11;
    edges(4);
    rd(3'd5, v); chk("R7 both edges rise", v, 16'h0700);
    rd(3'd4, v); chk("R7 ch1 off", v, 16'h0008);

    // R9 set and clear in the same cycle: set wins
    wr(3'd4, 16'h001F);
    wr(3'd1, 16'h0800);
    cap_in = 2'b00;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr(3'd4, 16'h0008);
    rd(3'd4, v); chk("R9 set wins over clear", v, 16'h0008);
    rd(3'd5, v); chk("R8 cap0 both edges fall", v, 16'h0800);
    chk("R10 irq mirrors flags", {11'd0, irq_flags}, 16'h0008);
    wr(3'd4, 16'h0008);
    rd(3'd4, v); chk("R9 cleared after", v, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule